// File: doc/BRIEF.md
# Byte-Window Instruction RAM Loader

This block gives a host, through a narrow byte-wide register bus, load and read-back access to a 512-word by 32-bit instruction store. The host sets a 9-bit word pointer with two pointer registers. It then moves data through a single byte-wide window register. A four-state byte-lane machine splits each 32-bit word into bytes, least significant byte first. For writes it builds the word in a holding register and commits it to the RAM on the fourth byte. For reads it selects the current byte of the addressed word. After the fourth byte the pointer steps to the next word and wraps from 511 to 0.

A control register has two bits. One enables writes through the window. The other drives a reset output that keeps the instruction sequencer in reset while code is loaded. The register map is: offset 0 control, offset 1 data window, offset 2 pointer low byte, offset 3 pointer high bit.

The lane machine has states LANE_B0, LANE_B1, LANE_B2 and LANE_B3. An accepted window access (a read, or a write while loading is enabled) moves it to the next state: B0 to B1, B1 to B2, B2 to B3, and B3 back to B0 together with a pointer step. A write to either pointer register returns it to LANE_B0 from any state. A write to the window while loading is disabled leaves it where it is.

Top module: `ibl_loader`

## Requirements
- R1: After reset the control register reads 0x02, both pointer registers read 0, `seq_rst` is 1, `load_en` is 0 and the lane machine is in LANE_B0.
- R2: The control register is at offset 0. Bit 0 enables loading and is driven on `load_en`. Bit 1 is driven on `seq_rst`. Reads return both bits with zeros above them.
- R3: The pointer low register (offset 2) holds pointer bits 7..0. The pointer high register (offset 3) keeps only written bit 0 as pointer bit 8 and reads back with bits 7..1 as zero.
- R4: Four successive writes to the window (offset 1), with loading enabled, store one 32-bit word at the pointer: the first byte in bits 7..0 and the fourth in bits 31..24.
- R5: The pointer increments after the fourth byte of a word and is unchanged after the first three.
- R6: Reads of the window return the bytes of the word at the pointer in the same lane order. The pointer advances after the fourth read.
- R7: A window write made while loading is disabled changes no RAM content, no lane position and no pointer.
- R8: A write to either pointer register returns the lane machine to LANE_B0, and any partly built word is discarded.
- R9: The pointer wraps from 511 to 0 after the fourth byte of word 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hb_addr | input | 2 | Register offset |
| hb_wr | input | 1 | Write strobe, one cycle per byte |
| hb_rd | input | 1 | Read strobe, one cycle per byte |
| hb_wdata | input | 8 | Write data |
| hb_rdata | output | 8 | Read data for the offset in the same cycle |
| load_en | output | 1 | Control bit 0: window writes allowed |
| seq_rst | output | 1 | Control bit 1: sequencer held in reset |

## Verification
The window is exercised in several ways:
- Two back-to-back words with distinct bytes, read back in order, expose lane-order and byte-position errors.
- A partial word followed by a pointer rewrite and a full word shows whether the lane machine restarts or a stale partial word leaks in.
- Writes with loading disabled, mixed with a later enabled word, separate "ignored" from "ignored but lane advanced".
- A word at address 511 shows whether the pointer wraps to 0 and the high bit clears.

// File: rtl/ibl_pkg.sv
package ibl_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        LANE_B0 = 2'd0,
        LANE_B1 = 2'd1,
        LANE_B2 = 2'd2,
        LANE_B3 = 2'd3
    } lane_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_WIN  = 2'd1;
    localparam logic [1:0] REG_ALO  = 2'd2;
    localparam logic [1:0] REG_AHI  = 2'd3;
endpackage

// File: rtl/ibl_lane_fsm.sv
module ibl_lane_fsm
    import ibl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  adv,
    output lane_e lane,
    output logic  last
);
    lane_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LANE_B0;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (clr) begin
            state_nx = LANE_B0;
        end else if (adv) begin
            unique case (state)
                LANE_B0: state_nx = LANE_B1;
                LANE_B1: state_nx = LANE_B2;
                LANE_B2: state_nx = LANE_B3;
                LANE_B3: state_nx = LANE_B0;
            endcase
        end
    end

    always_comb begin
        lane = state;
        last = (state == LANE_B3);
    end

    // R8: pointer write restarts the lane sequence
    p_lane_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> state == LANE_B0);
endmodule

// File: rtl/ibl_addr_ctr.sv
module ibl_addr_ctr #(
    parameter int ADDR_W = 9,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [BYTE_W-1:0] din,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - BYTE_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (ld_lo) begin
            addr[BYTE_W-1:0] <= din;
        end else if (ld_hi) begin
            addr[ADDR_W-1:BYTE_W] <= din[HI_W-1:0];
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/ibl_word_ram.sv
module ibl_word_ram #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ibl_loader.sv
module ibl_loader
    import ibl_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  hb_addr,
    input  logic        hb_wr,
    input  logic        hb_rd,
    input  logic [7:0]  hb_wdata,
    output logic [7:0]  hb_rdata,
    output logic        load_en,
    output logic        seq_rst
);
    localparam int HOLD_W = DATA_W - BYTE_W;
    localparam int HI_W   = ADDR_W - BYTE_W;

    logic              ctrl_le, ctrl_rst;
    logic [ADDR_W-1:0] word_addr;
    logic [HOLD_W-1:0] hold;
    logic [DATA_W-1:0] rd_word;
    lane_e             lane;
    logic              lane_last;
    logic              sel_win, win_wr, win_rd, win_adv;
    logic              ld_lo, ld_hi, ram_we;

    assign sel_win = (hb_addr == REG_WIN);
    assign win_wr  = sel_win && hb_wr;
    assign win_rd  = sel_win && hb_rd && !hb_wr;
    assign win_adv = (win_wr && ctrl_le) || win_rd;
    assign ld_lo   = hb_wr && (hb_addr == REG_ALO);
    assign ld_hi   = hb_wr && (hb_addr == REG_AHI);
    assign ram_we  = win_wr && ctrl_le && lane_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_le  <= 1'b0;
            ctrl_rst <= 1'b1;
        end else if (hb_wr && hb_addr == REG_CTRL) begin
            ctrl_le  <= hb_wdata[0];
            ctrl_rst <= hb_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
        end else if (win_wr && ctrl_le && !lane_last) begin
            hold[int'(lane)*BYTE_W +: BYTE_W] <= hb_wdata;
        end
    end

    ibl_lane_fsm u_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ld_lo || ld_hi),
        .adv   (win_adv),
        .lane  (lane),
        .last  (lane_last)
    );

    ibl_addr_ctr #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (ld_lo),
        .ld_hi (ld_hi),
        .din   (hb_wdata),
        .step  (win_adv && lane_last),
        .addr  (word_addr)
    );

    ibl_word_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (word_addr),
        .wdata ({hb_wdata, hold}),
        .raddr (word_addr),
        .rdata (rd_word)
    );

    always_comb begin
        hb_rdata = '0;
        unique case (hb_addr)
            REG_CTRL: hb_rdata = {6'b0, ctrl_rst, ctrl_le};
            REG_WIN:  hb_rdata = rd_word[int'(lane)*BYTE_W +: BYTE_W];
            REG_ALO:  hb_rdata = word_addr[BYTE_W-1:0];
            REG_AHI:  hb_rdata = {{(BYTE_W-HI_W){1'b0}}, word_addr[ADDR_W-1:BYTE_W]};
        endcase
    end

    assign load_en = ctrl_le;
    assign seq_rst = ctrl_rst;

    // R5, R9: a completed word steps the pointer by one, modulo depth
    p_step_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_adv && lane_last) |=> word_addr == $past(word_addr) + 1'b1);
    // R5: bytes 0..2 leave the pointer alone
    p_hold_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_adv && !lane_last) |=> $stable(word_addr));
    // R7: disabled writes leave lane and pointer unchanged
    p_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && !ctrl_le) |=> ($stable(lane) && $stable(word_addr)));
    // R2: control bit 1 reaches the reset output
    p_seqrst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_wr && hb_addr == REG_CTRL) |=> seq_rst == $past(hb_wdata[1]));
endmodule

// File: tb/ibl_loader_test.sv
`timescale 1ns/1ps
module ibl_loader_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] hb_addr = '0;
    logic       hb_wr = 1'b0;
    logic       hb_rd = 1'b0;
    logic [7:0] hb_wdata = '0;
    logic [7:0] hb_rdata;
    logic       load_en, seq_rst;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    ibl_loader uut (
        .clk(clk), .rst_n(rst_n), .hb_addr(hb_addr), .hb_wr(hb_wr),
        .hb_rd(hb_rd), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
        .load_en(load_en), .seq_rst(seq_rst)
    );

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        hb_addr = a; hb_wdata = d; hb_wr = 1'b1; hb_rd = 1'b0;
        @(posedge clk); #1;
        hb_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        hb_addr = a; hb_rd = 1'b1; hb_wr = 1'b0;
        @(posedge clk); #1;
        hb_rd = 1'b0;
    endtask

    task automatic chk(input logic act, input logic e, input string t);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", t, act, e);
        end
    endtask

    // monitor: pops the expected byte for every read strobe, mid-cycle
    always @(negedge clk) begin
        if (rst_n && hb_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (hb_rdata !== e) begin
                bad++;
                $display("FAIL %s: got %02h expected %02h", t, hb_rdata, e);
            end
        end
    end

    task automatic set_ptr(input logic [8:0] p);
        wr(2'd3, {7'b0, p[8]});
        wr(2'd2, p[7:0]);
    endtask

    initial begin
        #100000000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset state
        chk(seq_rst, 1'b1, "R1 seq_rst");
        chk(load_en, 1'b0, "R1 load_en");
        rd(2'd0, 8'h02, "R1 ctrl");
        rd(2'd2, 8'h00, "R1 ptr lo");
        rd(2'd3, 8'h00, "R1 ptr hi");

        // R2: control bits
        wr(2'd0, 8'h01);
        chk(load_en, 1'b1, "R2 load_en");
        chk(seq_rst, 1'b0, "R2 seq_rst");
        rd(2'd0, 8'h01, "R2 ctrl");
        wr(2'd0, 8'hFF);
        chk(seq_rst, 1'b1, "R2 seq_rst set");
        rd(2'd0, 8'h03, "R2 ctrl upper bits");
        wr(2'd0, 8'h01);

        // R3: pointer registers
        wr(2'd3, 8'hFF);
        rd(2'd3, 8'h01, "R3 ptr hi");
        wr(2'd2, 8'hA5);
        rd(2'd2, 8'hA5, "R3 ptr lo");

        // R4, R5: two words from pointer 5
        set_ptr(9'd5);
        wr(2'd1, 8'h11);
        rd(2'd2, 8'h05, "R5 after byte 1");
        wr(2'd1, 8'h22);
        wr(2'd1, 8'h33);
        rd(2'd2, 8'h05, "R5 after byte 3");
        wr(2'd1, 8'h44);
        rd(2'd2, 8'h06, "R5 after byte 4");
        wr(2'd1, 8'h55); wr(2'd1, 8'h66); wr(2'd1, 8'h77); wr(2'd1, 8'h88);
        rd(2'd2, 8'h07, "R5 second word");

        // R4, R6: read back in lane order
        set_ptr(9'd5);
        rd(2'd1, 8'h11, "R4 lane0");
        rd(2'd1, 8'h22, "R4 lane1");
        rd(2'd1, 8'h33, "R4 lane2");
        rd(2'd2, 8'h05, "R6 no step mid-word");
        rd(2'd1, 8'h44, "R4 lane3");
        rd(2'd2, 8'h06, "R6 step after read 4");
        rd(2'd1, 8'h55, "R6 word6 lane0");
        rd(2'd1, 8'h66, "R6 word6 lane1");
        rd(2'd1, 8'h77, "R6 word6 lane2");
        rd(2'd1, 8'h88, "R6 word6 lane3");

        // R8: partial word discarded on pointer write
        set_ptr(9'd10);
        wr(2'd1, 8'hAA); wr(2'd1, 8'hBB);
        set_ptr(9'd10);
        wr(2'd1, 8'h01); wr(2'd1, 8'h02); wr(2'd1, 8'h03); wr(2'd1, 8'h04);
        rd(2'd2, 8'h0B, "R8 pointer after realigned word");
        set_ptr(9'd10);
        rd(2'd1, 8'h01, "R8 lane0");
        rd(2'd1, 8'h02, "R8 lane1");
        rd(2'd1, 8'h03, "R8 lane2");
        rd(2'd1, 8'h04, "R8 lane3");

        // R7: writes ignored with loading disabled
        set_ptr(9'd20);
        wr(2'd1, 8'hDE); wr(2'd1, 8'hAD); wr(2'd1, 8'hBE); wr(2'd1, 8'hEF);
        wr(2'd0, 8'h00);
        set_ptr(9'd20);
        wr(2'd1, 8'h00); wr(2'd1, 8'h00); wr(2'd1, 8'h00); wr(2'd1, 8'h00);
        rd(2'd2, 8'h14, "R7 pointer unchanged");
        rd(2'd1, 8'hDE, "R7 ram lane0 kept");
        rd(2'd1, 8'hAD, "R7 ram lane1 kept");
        rd(2'd1, 8'hBE, "R7 ram lane2 kept");
        rd(2'd1, 8'hEF, "R7 ram lane3 kept");
        set_ptr(9'd20);
        wr(2'd1, 8'h99);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'hC1); wr(2'd1, 8'hC2); wr(2'd1, 8'hC3);
        rd(2'd2, 8'h14, "R7 lane not advanced");
        wr(2'd1, 8'hC4);
        rd(2'd2, 8'h15, "R7 word completes on 4th enabled byte");
        set_ptr(9'd20);
        rd(2'd1, 8'hC1, "R7 lane0");
        rd(2'd1, 8'hC2, "R7 lane1");
        rd(2'd1, 8'hC3, "R7 lane2");
        rd(2'd1, 8'hC4, "R7 lane3");

        // R9: wrap from 511
        set_ptr(9'd511);
        wr(2'd1, 8'hF0); wr(2'd1, 8'hF1); wr(2'd1, 8'hF2); wr(2'd1, 8'hF3);
        rd(2'd2, 8'h00, "R9 ptr lo wraps");
        rd(2'd3, 8'h00, "R9 ptr hi wraps");
        set_ptr(9'd511);
        rd(2'd1, 8'hF0, "R9 lane0");
        rd(2'd1, 8'hF1, "R9 lane1");
        rd(2'd1, 8'hF2, "R9 lane2");
        rd(2'd1, 8'hF3, "R9 lane3");
        rd(2'd2, 8'h00, "R9 read wraps");

        @(posedge clk); #1;
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule